// File: doc/BRIEF.md
# Configuration Mechanism Address Translator

This host-bridge block sits on the CPU I/O request path and turns accesses to two fixed I/O ports into configuration cycles. A dword write to the address port (0xCF8) stores an enable flag plus the bus, device, function and register numbers of the target. A dword access to the data port (0xCFC) then becomes a configuration read or write toward the device that the stored address selects. The request carries the decoded fields and a one-hot slot select line that is derived from the device number.

The CPU side uses a held request with a single-cycle ready pulse. The configuration side uses a held request that completes on an acknowledge, and a hit flag reports whether any target responded. The block claims only dword accesses to its two ports. Every other access is left for ordinary I/O decode: the block does not claim it and does not answer it.

Top module: `cfg_addr_xlate`

## Requirements
- R1: After reset the address port reads back 0x00000000 and `cfg_req_o` is low.
- R2: Only accesses with `io_size_i` = 2'b10 (dword) to address 0xCF8 or 0xCFC are claimed. Byte (00), word (01) and reserved (11) sizes, and dwords to any other address, leave `io_claim_o` low. They never raise `io_rdy_o` and do not change the address register.
- R3: A dword write to 0xCF8 stores the data with bits 30:24 and 1:0 forced to zero. A dword read of 0xCF8 returns the stored value at full width.
- R4: With bit 31 of the stored address set, an access to 0xCFC raises `cfg_req_o` one cycle after acceptance. The request carries bus = bits 23:16, device = bits 15:11, function = bits 10:8 and register = bits 7:2 of the stored address, with `cfg_we_o` equal to the access direction and the write data forwarded.
- R5: While `cfg_req_o` is high, `cfg_idsel_o` has exactly one bit set, at the index equal to the device number.
- R6: With bit 31 of the stored address clear, a 0xCFC read returns 0xFFFFFFFF and a 0xCFC write raises no configuration request.
- R7: A configuration read returns `cfg_rdata_i` when `cfg_hit_i` is high at acknowledge and 0xFFFFFFFF otherwise.
- R8: `cfg_req_o` and its fields stay stable until `cfg_ack_i`. `io_rdy_o` rises in the cycle after the acknowledge and not before.
- R9: `io_rdy_o` is a single-cycle pulse. For 0xCF8 accesses and disabled 0xCFC accesses it rises one cycle after acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| io_req_i | input | 1 | I/O request, held until `io_rdy_o` |
| io_addr_i | input | 16 | I/O port address |
| io_size_i | input | 2 | Access size: 00 byte, 01 word, 10 dword, 11 reserved |
| io_we_i | input | 1 | 1 = write |
| io_wdata_i | input | 32 | Write data |
| io_claim_o | output | 1 | Access is decoded by this block |
| io_rdy_o | output | 1 | One-cycle completion pulse |
| io_rdata_o | output | 32 | Read data, valid with `io_rdy_o` |
| cfg_req_o | output | 1 | Configuration request, held until acknowledge |
| cfg_we_o | output | 1 | Configuration write |
| cfg_bus_o | output | 8 | Bus number |
| cfg_dev_o | output | 5 | Device number |
| cfg_fn_o | output | 3 | Function number |
| cfg_reg_o | output | 6 | Dword register number |
| cfg_wdata_o | output | 32 | Configuration write data |
| cfg_idsel_o | output | 32 | One-hot slot select |
| cfg_ack_i | input | 1 | Configuration acknowledge |
| cfg_hit_i | input | 1 | A target responded |
| cfg_rdata_i | input | 32 | Configuration read data |

## Verification
The hardest situation to reach from the ports is a configuration request that waits several cycles before its acknowledge, because only then do field stability and the withheld ready pulse matter. The bench sweeps all 32 device numbers and varies the acknowledge delay from zero to three cycles with each device. It checks on every waiting cycle that the fields hold and that ready stays low. Junk bits in the reserved positions, and accesses that the block must not claim, are placed between these sweeps so that each one is caught by the address readback that follows it.

// File: rtl/cfg_xlate_pkg.sv
package cfg_xlate_pkg;
  localparam int unsigned IO_AW   = 16;
  localparam int unsigned DW      = 32;
  localparam int unsigned BUS_W   = 8;
  localparam int unsigned DEV_W   = 5;
  localparam int unsigned FN_W    = 3;
  localparam int unsigned REG_W   = 6;
  localparam int unsigned N_SLOT  = 1 << DEV_W;
  localparam logic [IO_AW-1:0] PORT_ADDR = 16'h0CF8;
  localparam logic [IO_AW-1:0] PORT_DATA = 16'h0CFC;

  typedef enum logic [1:0] {
    SZ_BYTE  = 2'b00,
    SZ_WORD  = 2'b01,
    SZ_DWORD = 2'b10,
    SZ_RSVD  = 2'b11
  } io_size_e;

  typedef struct packed {
    logic [BUS_W-1:0] bus;
    logic [DEV_W-1:0] dev;
    logic [FN_W-1:0]  fn;
    logic [REG_W-1:0] regn;
  } cfg_tgt_t;
endpackage

// File: rtl/cfg_port_decode.sv
module cfg_port_decode
  import cfg_xlate_pkg::*;
(
  input  logic             req_i,
  input  logic [IO_AW-1:0] addr_i,
  input  logic [1:0]       size_i,
  output logic             claim_o,
  output logic             is_data_o
);
  logic dword, hit_a, hit_d;
  always_comb begin
    dword     = (size_i == SZ_DWORD);
    hit_a     = (addr_i == PORT_ADDR);
    hit_d     = (addr_i == PORT_DATA);
    claim_o   = req_i && dword && (hit_a || hit_d);
    is_data_o = hit_d;
  end
endmodule

// File: rtl/cfg_addr_reg.sv
module cfg_addr_reg
  import cfg_xlate_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] q_o,
  output logic          en_o,
  output cfg_tgt_t      tgt_o
);
  localparam int unsigned FLD_W = BUS_W + DEV_W + FN_W + REG_W;
  logic             en_q;
  logic [FLD_W-1:0] fld_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q  <= 1'b0;
      fld_q <= '0;
    end else if (we_i) begin
      en_q  <= wdata_i[DW-1];
      fld_q <= wdata_i[FLD_W+1:2];
    end
  end

  // reserved bits 30:24 and 1:0 always read zero
  assign q_o   = {en_q, {(DW-1-FLD_W-2){1'b0}}, fld_q, 2'b00};
  assign en_o  = en_q;
  assign tgt_o = fld_q;
endmodule

// File: rtl/cfg_idsel_dec.sv
module cfg_idsel_dec
  import cfg_xlate_pkg::*;
(
  input  logic [DEV_W-1:0]  dev_i,
  output logic [N_SLOT-1:0] idsel_o
);
  for (genvar i = 0; i < N_SLOT; i++) begin : g_sel
    assign idsel_o[i] = (dev_i == DEV_W'(i));
  end
endmodule

// File: rtl/cfg_seq.sv
module cfg_seq
  import cfg_xlate_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          claim_i,
  input  logic          is_data_i,
  input  logic          we_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          en_i,
  input  cfg_tgt_t      tgt_i,
  input  logic [DW-1:0] addr_q_i,
  output logic          addr_we_o,
  output logic          rdy_o,
  output logic [DW-1:0] rdata_o,
  output logic          cfg_req_o,
  output logic          cfg_we_o,
  output cfg_tgt_t      cfg_tgt_o,
  output logic [DW-1:0] cfg_wdata_o,
  input  logic          cfg_ack_i,
  input  logic          cfg_hit_i,
  input  logic [DW-1:0] cfg_rdata_i
);
  typedef enum logic [1:0] {S_IDLE, S_CFG, S_DONE} st_e;
  st_e st_q;
  logic accept;

  assign accept    = claim_i && (st_q == S_IDLE);
  assign addr_we_o = accept && !is_data_i && we_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q        <= S_IDLE;
      rdata_o     <= '0;
      cfg_we_o    <= 1'b0;
      cfg_tgt_o   <= '0;
      cfg_wdata_o <= '0;
    end else begin
      unique case (st_q)
        S_IDLE: if (accept) begin
          if (!is_data_i) begin
            rdata_o <= we_i ? '0 : addr_q_i;
            st_q    <= S_DONE;
          end else if (!en_i) begin
            rdata_o <= we_i ? '0 : '1;
            st_q    <= S_DONE;
          end else begin
            cfg_we_o    <= we_i;
            cfg_tgt_o   <= tgt_i;
            cfg_wdata_o <= wdata_i;
            st_q        <= S_CFG;
          end
        end
        S_CFG: if (cfg_ack_i) begin
          rdata_o <= cfg_we_o ? '0 : (cfg_hit_i ? cfg_rdata_i : '1);
          st_q    <= S_DONE;
        end
        S_DONE: st_q <= S_IDLE;
        default: st_q <= S_IDLE;
      endcase
    end
  end

  assign cfg_req_o = (st_q == S_CFG);
  assign rdy_o     = (st_q == S_DONE);

  p_req_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_req_o && !cfg_ack_i |=> cfg_req_o && $stable(cfg_tgt_o) && $stable(cfg_we_o)
      && $stable(cfg_wdata_o) && !rdy_o);
  p_rdy_after_ack_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_req_o && cfg_ack_i |=> rdy_o && !cfg_req_o);
  p_rdy_pulse_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rdy_o |=> !rdy_o);
endmodule

// File: rtl/cfg_addr_xlate.sv
module cfg_addr_xlate
  import cfg_xlate_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              io_req_i,
  input  logic [IO_AW-1:0]  io_addr_i,
  input  logic [1:0]        io_size_i,
  input  logic              io_we_i,
  input  logic [DW-1:0]     io_wdata_i,
  output logic              io_claim_o,
  output logic              io_rdy_o,
  output logic [DW-1:0]     io_rdata_o,
  output logic              cfg_req_o,
  output logic              cfg_we_o,
  output logic [BUS_W-1:0]  cfg_bus_o,
  output logic [DEV_W-1:0]  cfg_dev_o,
  output logic [FN_W-1:0]   cfg_fn_o,
  output logic [REG_W-1:0]  cfg_reg_o,
  output logic [DW-1:0]     cfg_wdata_o,
  output logic [N_SLOT-1:0] cfg_idsel_o,
  input  logic              cfg_ack_i,
  input  logic              cfg_hit_i,
  input  logic [DW-1:0]     cfg_rdata_i
);
  logic          is_data, addr_we, en;
  logic [DW-1:0] addr_q;
  cfg_tgt_t      tgt, cfg_tgt;

  cfg_port_decode u_dec (
    .req_i(io_req_i), .addr_i(io_addr_i), .size_i(io_size_i),
    .claim_o(io_claim_o), .is_data_o(is_data)
  );

  cfg_addr_reg u_areg (
    .clk_i(clk_i), .rst_ni(rst_ni), .we_i(addr_we), .wdata_i(io_wdata_i),
    .q_o(addr_q), .en_o(en), .tgt_o(tgt)
  );

  cfg_seq u_seq (
    .clk_i(clk_i), .rst_ni(rst_ni), .claim_i(io_claim_o), .is_data_i(is_data),
    .we_i(io_we_i), .wdata_i(io_wdata_i), .en_i(en), .tgt_i(tgt), .addr_q_i(addr_q),
    .addr_we_o(addr_we), .rdy_o(io_rdy_o), .rdata_o(io_rdata_o),
    .cfg_req_o(cfg_req_o), .cfg_we_o(cfg_we_o), .cfg_tgt_o(cfg_tgt),
    .cfg_wdata_o(cfg_wdata_o), .cfg_ack_i(cfg_ack_i), .cfg_hit_i(cfg_hit_i),
    .cfg_rdata_i(cfg_rdata_i)
  );

  cfg_idsel_dec u_idsel (.dev_i(cfg_tgt.dev), .idsel_o(cfg_idsel_o));

  assign cfg_bus_o = cfg_tgt.bus;
  assign cfg_dev_o = cfg_tgt.dev;
  assign cfg_fn_o  = cfg_tgt.fn;
  assign cfg_reg_o = cfg_tgt.regn;

  p_idsel_onehot_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_req_o |-> ($countones(cfg_idsel_o) == 1) && cfg_idsel_o[cfg_dev_o]);
  p_en_gate_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cfg_req_o) |-> addr_q[DW-1]);
  p_pass_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    io_req_i && !io_claim_o |=> !io_rdy_o && $stable(addr_q));
  p_rsvd_zero_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    io_rdy_o && !cfg_we_o && io_claim_o && !is_data && !io_we_i
      |-> io_rdata_o[30:24] == 7'd0 && io_rdata_o[1:0] == 2'd0);
endmodule

// File: tb/tb_cfg_addr_xlate.sv
module tb_cfg_addr_xlate;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        io_req = 1'b0;
  logic [15:0] io_addr = '0;
  logic [1:0]  io_size = '0;
  logic        io_we = 1'b0;
  logic [31:0] io_wdata = '0;
  logic        io_claim, io_rdy, cfg_req, cfg_we;
  logic [31:0] io_rdata, cfg_wdata, cfg_idsel;
  logic [7:0]  cfg_bus;
  logic [4:0]  cfg_dev;
  logic [2:0]  cfg_fn;
  logic [5:0]  cfg_reg;
  logic        cfg_ack = 1'b0;
  logic        cfg_hit = 1'b0;
  logic [31:0] cfg_rdata = '0;

  int total = 0;
  int bad = 0;

  always #2 clk = ~clk;

  cfg_addr_xlate dut (
    .clk_i(clk), .rst_ni(rst_n), .io_req_i(io_req), .io_addr_i(io_addr),
    .io_size_i(io_size), .io_we_i(io_we), .io_wdata_i(io_wdata),
    .io_claim_o(io_claim), .io_rdy_o(io_rdy), .io_rdata_o(io_rdata),
    .cfg_req_o(cfg_req), .cfg_we_o(cfg_we), .cfg_bus_o(cfg_bus), .cfg_dev_o(cfg_dev),
    .cfg_fn_o(cfg_fn), .cfg_reg_o(cfg_reg), .cfg_wdata_o(cfg_wdata),
    .cfg_idsel_o(cfg_idsel), .cfg_ack_i(cfg_ack), .cfg_hit_i(cfg_hit),
    .cfg_rdata_i(cfg_rdata)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%08h exp=%08h", req, act, exp);
    end
  endtask

  // captured per access
  logic [31:0] got_rdata;
  int          got_n;
  bit          got_seen, got_unstable, got_early;
  logic [7:0]  s_bus;
  logic [4:0]  s_dev;
  logic [2:0]  s_fn;
  logic [5:0]  s_reg;
  logic        s_we;
  logic [31:0] s_wdata, s_idsel;

  task automatic io_acc(input logic [15:0] a, input logic [1:0] sz, input bit we,
                        input logic [31:0] wd, input int dly, input bit hit,
                        input logic [31:0] rsp);
    int w;
    bit done;
    w = 0; done = 0;
    got_n = 0; got_seen = 0; got_unstable = 0; got_early = 0; got_rdata = '0;
    @(negedge clk);
    io_req = 1'b1; io_addr = a; io_size = sz; io_we = we; io_wdata = wd;
    while (!done && got_n < 20) begin
      @(negedge clk);
      got_n++;
      cfg_ack = 1'b0;
      if (io_rdy) begin
        got_rdata = io_rdata;
        done = 1;
        io_req = 1'b0;
      end else if (cfg_req) begin
        if (!got_seen) begin
          got_seen = 1;
          s_bus = cfg_bus; s_dev = cfg_dev; s_fn = cfg_fn; s_reg = cfg_reg;
          s_we = cfg_we; s_wdata = cfg_wdata; s_idsel = cfg_idsel;
        end else if (cfg_bus != s_bus || cfg_dev != s_dev || cfg_fn != s_fn ||
                     cfg_reg != s_reg || cfg_we != s_we || cfg_wdata != s_wdata)
          got_unstable = 1;
        if (w == dly) begin
          cfg_ack = 1'b1; cfg_hit = hit; cfg_rdata = rsp;
        end
        w++;
      end
    end
    io_req = 1'b0;
  endtask

  // pass-through: hold request several cycles, expect no claim and no ready
  task automatic io_ignored(input logic [15:0] a, input logic [1:0] sz, input bit we,
                            input logic [31:0] wd);
    bit any;
    any = 0;
    @(negedge clk);
    io_req = 1'b1; io_addr = a; io_size = sz; io_we = we; io_wdata = wd;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      if (io_claim || io_rdy || cfg_req) any = 1;
    end
    io_req = 1'b0;
    chk(!any, "R2 unclaimed access answered", {30'd0, io_claim, io_rdy}, 32'd0);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired act=%08h exp=%08h", 32'd1, 32'd0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : main
    logic [31:0] a_val, exp_a, rsp;
    repeat (3) @(negedge clk);
    chk(cfg_req == 1'b0, "R1 cfg_req at reset", {31'd0, cfg_req}, 32'd0);
    rst_n = 1'b1;
    io_acc(16'h0CF8, 2'b10, 1'b0, '0, 0, 0, '0);
    chk(got_rdata == 32'd0, "R1 address reset value", got_rdata, 32'd0);
    chk(got_n == 1, "R9 ready latency addr port", got_n, 1);

    // sweep every device number; junk in reserved bits
    for (int d = 0; d < 32; d++) begin
      logic [7:0] b;
      logic [2:0] f;
      logic [5:0] r;
      b = 8'((d * 37 + 5) % 256);
      f = 3'(d % 8);
      r = 6'((d * 5 + 3) % 64);
      a_val = {1'b1, 7'(d * 13 + 1), b, 5'(d), f, r, 2'(d % 4)};
      exp_a = {1'b1, 7'd0, b, 5'(d), f, r, 2'b00};
      io_acc(16'h0CF8, 2'b10, 1'b1, a_val, 0, 0, '0);
      chk(got_n == 1, "R9 ready latency addr write", got_n, 1);
      io_acc(16'h0CF8, 2'b10, 1'b0, '0, 0, 0, '0);
      chk(got_rdata == exp_a, "R3 address readback", got_rdata, exp_a);

      // config write with acknowledge delay
      io_acc(16'h0CFC, 2'b10, 1'b1, 32'hC0DE0000 + 32'(d), d % 4, 1, '0);
      chk(got_seen, "R4 write request raised", {31'd0, got_seen}, 1);
      chk({s_bus, s_dev, s_fn, s_reg} == {b, 5'(d), f, r}, "R4 request fields",
          {8'd0, s_bus, s_dev, s_fn, s_reg}, {8'd0, b, 5'(d), f, r});
      chk(s_we == 1'b1 && s_wdata == 32'hC0DE0000 + 32'(d), "R4 write dir/data",
          s_wdata, 32'hC0DE0000 + 32'(d));
      chk(s_idsel == (32'd1 << d), "R5 idsel one-hot", s_idsel, 32'd1 << d);
      chk(!got_unstable, "R8 fields stable while waiting", {31'd0, got_unstable}, 0);
      chk(got_n == 2 + d % 4, "R8 ready after acknowledge", got_n, 2 + d % 4);

      // config read, hit or miss
      rsp = 32'h5A000000 ^ exp_a;
      io_acc(16'h0CFC, 2'b10, 1'b0, '0, (d + 1) % 4, (d % 3) != 0, rsp);
      chk(got_seen && s_we == 1'b0, "R4 read request dir", {31'd0, s_we}, 0);
      chk(s_idsel == (32'd1 << d), "R5 idsel on read", s_idsel, 32'd1 << d);
      if (d % 3 != 0)
        chk(got_rdata == rsp, "R7 read data on hit", got_rdata, rsp);
      else
        chk(got_rdata == 32'hFFFFFFFF, "R7 read miss all-ones", got_rdata, 32'hFFFFFFFF);
      chk(got_n == 2 + (d + 1) % 4, "R8 read ready timing", got_n, 2 + (d + 1) % 4);
    end

    // enable clear
    exp_a = {1'b0, 7'd0, 8'h12, 5'd7, 3'd2, 6'd9, 2'b00};
    io_acc(16'h0CF8, 2'b10, 1'b1, exp_a | 32'h7F000003, 0, 0, '0);
    io_acc(16'h0CFC, 2'b10, 1'b0, '0, 0, 1, 32'h12345678);
    chk(!got_seen, "R6 no request when disabled", {31'd0, got_seen}, 0);
    chk(got_rdata == 32'hFFFFFFFF, "R6 disabled read all-ones", got_rdata, 32'hFFFFFFFF);
    chk(got_n == 1, "R9 disabled ready latency", got_n, 1);
    io_acc(16'h0CFC, 2'b10, 1'b1, 32'hDEADBEEF, 0, 1, '0);
    chk(!got_seen, "R6 disabled write no request", {31'd0, got_seen}, 0);

    // unclaimed sizes and addresses; address register must stay
    for (int s = 0; s < 4; s++) begin
      if (s == 2) continue;
      io_ignored(16'h0CF8, 2'(s), 1'b1, 32'hFFFFFFFF);
      io_ignored(16'h0CFC, 2'(s), 1'b0, '0);
    end
    io_ignored(16'h0CF4, 2'b10, 1'b1, 32'h80FFFFFC);
    io_ignored(16'h0CF9, 2'b10, 1'b1, 32'h80FFFFFC);
    io_ignored(16'h0D00, 2'b10, 1'b1, 32'h80FFFFFC);
    io_acc(16'h0CF8, 2'b10, 1'b0, '0, 0, 0, '0);
    chk(got_rdata == exp_a, "R2 address kept after ignored", got_rdata, exp_a);

    // reset mid-life returns to zero
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    io_acc(16'h0CF8, 2'b10, 1'b0, '0, 0, 0, '0);
    chk(got_rdata == 32'd0, "R1 address cleared by reset", got_rdata, 32'd0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule